// File: doc/BRIEF.md
# Pipelined Carry-Save Unsigned Multiplier

This block multiplies two unsigned operands of parameterized width `W` and returns the full `2W`-bit product. The work is split over `S = ceil(W / P)` pipeline stages. Stage `s` adds the partial products for multiplicand positions `s*P` to `s*P+P-1`. Each partial product is the multiplier shifted left by its position when that multiplicand bit is set, and zero when it is clear. A fresh operand pair may be presented on every clock. Each pair carries its own copy of both operands down the pipe, so stages working on different pairs never mix them.

The running total is held as two vectors, a sum and a carry, and is never resolved inside the stages. Each stage folds its partial products in with 3:2 carry-save compressors, so a stage's delay does not grow with the operand width. After the last stage, a single carry-propagate add merges the two vectors into the product.

The pipeline registers are trimmed to what the rest of the pipe still needs. The accumulator registers widen stage by stage, because an early partial total cannot yet fill `2W` bits. The multiplicand registers shrink stage by stage, because consumed bits are dropped. A valid flag travels in step with the data. The synchronous reset clears only that valid chain. The parameters must satisfy `1 <= P < W`, so there are at least two stages.

Top module: `pmul_top`

## Requirements
- R1: For every accepted pair, `prod` equals the unsigned product `mplier * mcand` in all `2W` bits.
- R2: A pair presented with `in_vld` high in cycle c shows up on `prod`, with `out_vld` high, in cycle c+S, where S = ceil(W/P). This is 4 for W=16, P=4 and 3 for W=10, P=4.
- R3: A new pair is accepted every cycle. Back-to-back pairs each yield their own product, one per cycle, in the order they were presented.
- R4: `out_vld` equals `in_vld` delayed by S cycles. A cycle with `in_vld` low produces a cycle with `out_vld` low.
- R5: Reset is synchronous and active high. `out_vld` is low while `rst` is high and for S cycles after its release, whatever pairs were in flight and whatever `in_vld` was during reset.
- R6: When W is not a multiple of P, the last stage adds only the W-(S-1)*P remaining positions, and products stay exact. This is checked at W=10, P=4, where the last stage adds 2 positions.
- R7: After stage s, the sum and carry registers are min((s+1)*P+W, 2W) bits wide. For a valid pair, neither vector has any set bit above that width before trimming.
- R8: A stage whose multiplicand bits at positions s*P to s*P+P-1 are all zero leaves the value sum+carry unchanged.
- R9: A zero operand gives 0. Both operands all ones give (2^W-1)^2. Single-bit operands 2^i and 2^j give 2^(i+j).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid chain |
| in_vld | input | 1 | Marks the operand pair in this cycle as a real operation |
| mplier | input | W | Multiplier, the operand that is shifted to form partial products |
| mcand | input | W | Multiplicand, whose bits select partial products |
| out_vld | output | 1 | Marks `prod` as the result of a pair presented S cycles earlier |
| prod | output | 2W | Unsigned product |

## Verification
The hardest case to reach from the ports is a reset that lands while several valid pairs are still inside the pipe. In that case the data registers keep stale totals while the valid chain must come back empty. The bench fills the pipe with back-to-back valid pairs and holds `in_vld` high during the one reset cycle. It then watches both output flags stay low for the full latency. Trimmed-width stress needs operands that drive the carry-save vectors to their width limits. All-ones operands and random bursts do this, and a second instance with a partially filled last stage runs the same stimulus.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    // Number of pipeline stages for operand width w and p positions per stage.
    function automatic int num_stages(int w, int p);
        return (w + p - 1) / p;
    endfunction

    // Accumulator width after stage s (s = -1 gives the width entering stage 0).
    function automatic int acc_w(int w, int p, int s);
        int n;
        n = (s + 1) * p + w;
        return (n > 2 * w) ? 2 * w : n;
    endfunction

    // Bit offset of stage s's accumulator slot in the flat accumulator bus.
    function automatic int acc_off(int w, int p, int s);
        int t;
        t = 0;
        for (int i = 0; i < s; i++) t += acc_w(w, p, i);
        return t;
    endfunction

    // Multiplicand bits still needed on entry to stage s.
    function automatic int mc_w(int w, int p, int s);
        return w - s * p;
    endfunction

    // Offset of the registered multiplicand slot for stage s (s >= 1).
    function automatic int mc_off(int w, int p, int s);
        int t;
        t = 0;
        for (int i = 1; i < s; i++) t += mc_w(w, p, i);
        return t;
    endfunction

    // Partial products handled by stage s (fewer in a partially filled last stage).
    function automatic int pp_count(int w, int p, int s);
        int r;
        r = w - s * p;
        return (r < p) ? r : p;
    endfunction

endpackage

// File: rtl/pmul_stage.sv
module pmul_stage #(
    parameter int W    = 16,
    parameter int P    = 4,
    parameter int IDX  = 0,
    parameter int AIN  = pmul_pkg::acc_w(W, P, IDX - 1),
    parameter int AOUT = pmul_pkg::acc_w(W, P, IDX),
    parameter int NB   = pmul_pkg::pp_count(W, P, IDX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld_in,
    input  logic [AIN-1:0]  sum_in,
    input  logic [AIN-1:0]  car_in,
    input  logic [W-1:0]    mpl,
    input  logic [NB-1:0]   mcd,
    output logic            vld_q,
    output logic [AOUT-1:0] sum_q,
    output logic [AOUT-1:0] car_q
);

    localparam int BASE = IDX * P;
    localparam int XW   = 2 * W;
    localparam int EW   = XW + 1;

    logic [XW-1:0] s_w;
    logic [XW-1:0] c_w;

    // Chain of 3:2 compressors, one per partial product of this stage.
    always_comb begin
        logic [XW-1:0] acc_s;
        logic [XW-1:0] acc_c;
        logic [XW-1:0] pp;
        logic [XW-1:0] nxt;
        acc_s = XW'(sum_in);
        acc_c = XW'(car_in);
        for (int j = 0; j < NB; j++) begin
            pp    = mcd[j] ? (XW'(mpl) << (BASE + j)) : '0;
            nxt   = acc_s ^ acc_c ^ pp;
            acc_c = ((acc_s & acc_c) | (acc_s & pp) | (acc_c & pp)) << 1;
            acc_s = nxt;
        end
        s_w = acc_s;
        c_w = acc_c;
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= vld_in;
        sum_q <= s_w[AOUT-1:0];
        car_q <= c_w[AOUT-1:0];
    end

    if (AOUT < XW) begin : g_trim_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            vld_in |-> (s_w[XW-1:AOUT] == '0 && c_w[XW-1:AOUT] == '0))
            else $error("stage %0d loses accumulator bits", IDX); // R7
    end

    AST_ZERO_SLICE_PASS: assert property (@(posedge clk) disable iff (rst)
        (vld_in && mcd == '0) |=>
        (EW'(sum_q) + EW'(car_q)) == $past(EW'(sum_in) + EW'(car_in)))
        else $error("stage %0d altered total on empty slice", IDX); // R8

    AST_ZERO_MULT: assert property (@(posedge clk) disable iff (rst)
        (vld_in && mpl == '0 && sum_in == '0 && car_in == '0) |=>
        (sum_q == '0 && car_q == '0))
        else $error("stage %0d nonzero total for zero multiplier", IDX); // R9

endmodule

// File: rtl/pmul_cpa.sv
module pmul_cpa #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           vld,
    input  logic [2*W-1:0] a,
    input  logic [2*W-1:0] b,
    output logic [2*W-1:0] sum
);

    logic co;

    assign {co, sum} = a + b;

    AST_NO_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
        vld |-> !co)
        else $error("final add overflowed the product width"); // R1

endmodule

// File: rtl/pmul_top.sv
module pmul_top #(
    parameter int W = 16,
    parameter int P = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  logic [W-1:0]   mplier,
    input  logic [W-1:0]   mcand,
    output logic           out_vld,
    output logic [2*W-1:0] prod
);

    import pmul_pkg::*;

    localparam int S        = num_stages(W, P);
    localparam int XW       = 2 * W;
    localparam int ACC_TOT  = acc_off(W, P, S);
    localparam int ACC_LAST = acc_off(W, P, S - 1);
    localparam int MC_TOT   = mc_off(W, P, S);

    logic [ACC_TOT-1:0] sum_bus;
    logic [ACC_TOT-1:0] car_bus;
    logic [S-1:0]       vld_bus;
    logic [W-1:0]       mpl_pipe [1:S-1];
    logic [MC_TOT-1:0]  mcd_bus;

    for (genvar s = 0; s < S; s++) begin : g_st
        localparam int AW = acc_w(W, P, s);
        localparam int AO = acc_off(W, P, s);
        localparam int NB = pp_count(W, P, s);
        localparam int MW = mc_w(W, P, s);

        if (s == 0) begin : g_head
            pmul_stage #(.W(W), .P(P), .IDX(0)) u_stage (
                .clk    (clk),
                .rst    (rst),
                .vld_in (in_vld),
                .sum_in ('0),
                .car_in ('0),
                .mpl    (mplier),
                .mcd    (mcand[NB-1:0]),
                .vld_q  (vld_bus[0]),
                .sum_q  (sum_bus[AO +: AW]),
                .car_q  (car_bus[AO +: AW])
            );

            always_ff @(posedge clk) begin
                mpl_pipe[1] <= mplier;
                mcd_bus[mc_off(W, P, 1) +: mc_w(W, P, 1)] <= mcand[W-1:P];
            end
        end else begin : g_body
            localparam int PAO = acc_off(W, P, s - 1);
            localparam int PAW = acc_w(W, P, s - 1);
            localparam int MO  = mc_off(W, P, s);

            logic [MW-1:0] mcd_cur;
            assign mcd_cur = mcd_bus[MO +: MW];

            pmul_stage #(.W(W), .P(P), .IDX(s)) u_stage (
                .clk    (clk),
                .rst    (rst),
                .vld_in (vld_bus[s-1]),
                .sum_in (sum_bus[PAO +: PAW]),
                .car_in (car_bus[PAO +: PAW]),
                .mpl    (mpl_pipe[s]),
                .mcd    (mcd_cur[NB-1:0]),
                .vld_q  (vld_bus[s]),
                .sum_q  (sum_bus[AO +: AW]),
                .car_q  (car_bus[AO +: AW])
            );

            if (s < S - 1) begin : g_pass
                always_ff @(posedge clk) begin
                    mpl_pipe[s+1] <= mpl_pipe[s];
                    mcd_bus[mc_off(W, P, s + 1) +: mc_w(W, P, s + 1)] <= mcd_cur[MW-1:P];
                end
            end
        end
    end

    pmul_cpa #(.W(W)) u_cpa (
        .clk (clk),
        .rst (rst),
        .vld (vld_bus[S-1]),
        .a   (sum_bus[ACC_LAST +: XW]),
        .b   (car_bus[ACC_LAST +: XW]),
        .sum (prod)
    );

    assign out_vld = vld_bus[S-1];

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_vld)
        else $error("valid output right after reset release"); // R5

endmodule

// File: tb/pmul_top_bench.sv
module pmul_top_bench;

    localparam int W1 = 16;
    localparam int P1 = 4;
    localparam int S1 = 4;
    localparam int W2 = 10;
    localparam int P2 = 4;
    localparam int S2 = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [W1-1:0] a = '0;
    logic [W1-1:0] b = '0;

    logic            out_vld1;
    logic [2*W1-1:0] prod1;
    logic            out_vld2;
    logic [2*W2-1:0] prod2;

    always #2 clk = ~clk;

    pmul_top #(.W(W1), .P(P1)) u_pmul_top (
        .clk(clk), .rst(rst), .in_vld(in_vld), .mplier(a), .mcand(b),
        .out_vld(out_vld1), .prod(prod1)
    );

    pmul_top #(.W(W2), .P(P2)) u_pmul_top_odd (
        .clk(clk), .rst(rst), .in_vld(in_vld), .mplier(a[W2-1:0]), .mcand(b[W2-1:0]),
        .out_vld(out_vld2), .prod(prod2)
    );

    typedef struct {
        bit               v;
        longint unsigned  p;
        int               tag;
    } exp_t;

    exp_t q1[$];
    exp_t q2[$];

    int n_chk = 0;
    int n_err = 0;
    int cur_tag = 1;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    function automatic string rname(int k);
        case (k)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            5: return "R5";
            8: return "R8";
            9: return "R9";
            default: return "R4";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < S1; i++) q1.push_back('{v: 1'b0, p: 64'd0, tag: 0});
        for (int i = 0; i < S2; i++) q2.push_back('{v: 1'b0, p: 64'd0, tag: 0});
    end

    // Reference model: one entry per clock, S entries deep.
    always @(posedge clk) begin
        if (rst) begin
            q1.delete();
            q2.delete();
            for (int i = 0; i < S1; i++) q1.push_back('{v: 1'b0, p: 64'd0, tag: 0});
            for (int i = 0; i < S2; i++) q2.push_back('{v: 1'b0, p: 64'd0, tag: 0});
        end else begin
            q1.push_back('{v: in_vld, p: 64'(a) * 64'(b), tag: cur_tag});
            q2.push_back('{v: in_vld, p: 64'(a[W2-1:0]) * 64'(b[W2-1:0]), tag: 6});
            void'(q1.pop_front());
            void'(q2.pop_front());
        end
    end

    task automatic cmp(string dut, string req, logic v_act, logic [63:0] p_act, exp_t e);
        n_chk++;
        if (v_act !== e.v) begin
            n_err++;
            $display("FAIL %s %s out_vld act=%0b exp=%0b", req, dut, v_act, e.v);
        end else if (e.v && p_act !== e.p) begin
            n_err++;
            $display("FAIL %s %s prod act=%0h exp=%0h", req, dut, p_act, e.p);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            cmp("w16", rname(q1[0].tag), out_vld1, 64'(prod1), q1[0]);
            cmp("w10", "R6", out_vld2, 64'(prod2), q2[0]);
        end
    end

    task automatic expect_int(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(bit v, logic [W1-1:0] x, logic [W1-1:0] y, int tag);
        @(negedge clk);
        in_vld  = v;
        a       = x;
        b       = y;
        cur_tag = tag;
    endtask

    initial begin
        int l1;
        int l2;
        repeat (4) @(negedge clk);
        // R5: outputs quiet while reset is held
        expect_int("R5", "out_vld w16 in reset", int'(out_vld1), 0);
        expect_int("R5", "out_vld w10 in reset", int'(out_vld2), 0);
        rst    = 1'b0;
        chk_on = 1'b1;

        // R9: corner operands, back to back
        drive(1, 16'h0000, 16'hFFFF, 9);
        drive(1, 16'hFFFF, 16'h0000, 9);
        drive(1, 16'hFFFF, 16'hFFFF, 9);
        drive(1, 16'h0001, 16'h0001, 9);
        drive(1, 16'h8000, 16'h8000, 9);
        for (int k = 0; k < W1; k++) drive(1, 16'(1 << k), 16'(1 << (W1 - 1 - k)), 9);
        drive(1, 16'hFFFF, 16'h03FF, 9);

        // R8: multiplicand with empty stage slices
        for (int k = 0; k < 20; k++) drive(1, 16'($urandom), 16'hF00F, 8);
        for (int k = 0; k < 20; k++) drive(1, 16'($urandom), 16'h0F00, 8);

        // R3: back-to-back random pairs
        for (int k = 0; k < 300; k++) drive(1, 16'($urandom), 16'($urandom), 3);

        // R4: random bubbles
        for (int k = 0; k < 200; k++) drive(1'($urandom), 16'($urandom), 16'($urandom), 4);

        // R1: skewed operand magnitudes
        for (int k = 0; k < 100; k++) drive(1, 16'($urandom) | 16'hF000, 16'($urandom % 64), 1);

        // R2: latency of a single isolated pair
        repeat (S1 + 3) drive(0, 16'h0000, 16'h0000, 2);
        drive(1, 16'h1234, 16'h0042, 2);
        l1 = 0;
        l2 = 0;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            if (n == 1) in_vld = 1'b0;
            if (l1 == 0 && out_vld1 === 1'b1) l1 = n;
            if (l2 == 0 && out_vld2 === 1'b1) l2 = n;
        end
        expect_int("R2", "latency w16", l1, S1);
        expect_int("R2", "latency w10", l2, S2);

        // R5: reset with valid pairs in flight and in_vld held high
        for (int k = 0; k < 3; k++) drive(1, 16'($urandom), 16'($urandom), 5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst    = 1'b0;
        in_vld = 1'b0;
        for (int n = 0; n <= S1; n++) begin
            @(negedge clk);
            expect_int("R5", "out_vld w16 after reset", int'(out_vld1), 0);
            expect_int("R5", "out_vld w10 after reset", int'(out_vld2), 0);
        end

        // R1: closing random burst, then drain
        for (int k = 0; k < 50; k++) drive(1, 16'($urandom), 16'($urandom), 1);
        repeat (S1 + 2) drive(0, 16'h0000, 16'h0000, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule